// File: doc/BRIEF.md
# Zero-Overhead Loop Body Cache

This block sits between program fetch and the instruction decoder and implements a hardware repeat construct. When the decoder reports a loop-start instruction with a non-zero body length, the block passes the next body words to the decoder from the program store and keeps a copy of each one. It then holds the fetch unit and replays the copy from its own storage for the remaining passes. A loop-start instruction with a zero body length replays the body captured earlier. It takes a short setup and then runs every pass from storage, without touching program memory.

While a loop runs from storage, the block asserts a fetch-hold output. The program counter therefore stays at the word after the body, or at the word after the replay instruction, and resumes there when the loop ends. A one-cycle done pulse marks the end of the loop. An invalid pulse reports a bad iteration count, a replay with nothing valid to replay, or a word that is not allowed inside a body. A cache-hit flag marks words that come from storage. A speed flag marks cached words whose class executes in one cycle from storage but in two cycles from the program store.

Top module: `zol_cache`

## Requirements
- R1: After reset, fetch hold, cache hit, speed flag, done and invalid are all low, and no valid cached body exists.
- R2: When fetch is not held, instr_o equals fetch_word_i, instr_valid_o equals fetch_valid_i and from_cache_o is low in the same cycle.
- R3: A loop-start (dec_is_loop_i) with dec_ni_i = N > 0 and a legal count K passes the next N valid words through and captures them. In the cycle after the N-th word, fetch_hold_o rises and the body is issued K-1 more times from storage, in order, one word per cycle, with from_cache_o and instr_valid_o high.
- R4: A loop-start whose count K is 0 or 1 raises invalid_o for exactly the next cycle and starts no loop. Counts from 2 to 127 are legal.
- R5: A body word presented with dec_eligible_i low abandons the loop, raises invalid_o in the next cycle and clears the valid body.
- R6: fast_o is high only for a word issued from storage whose bits 15:11 hold 0x19, 0x1B or 0x1F, and it is low for every other word.
- R7: A loop-start with dec_ni_i = 0, a legal K and a valid body holds fetch for two setup cycles with instr_valid_o low. It then issues the stored body K times from storage.
- R8: A loop-start with dec_ni_i = 0 and no valid body raises invalid_o in the next cycle and does not hold fetch.
- R9: loop_done_o pulses for exactly one cycle, in the cycle after the last stored word is issued. In that same cycle fetch_hold_o is low and words pass through again.
- R10: Cycles with fetch_valid_i low during capture are skipped. They neither count as body words nor enter storage.
- R11: While fetch_hold_o is high, fetch_word_i and the decoder inputs have no effect on the issued words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_word_i | input | WORD_W | Word from program memory |
| fetch_valid_i | input | 1 | fetch_word_i carries a new instruction |
| dec_is_loop_i | input | 1 | Decoder: current word is a loop-start |
| dec_ni_i | input | NI_W | Decoder: body length, 0 means replay |
| dec_k_i | input | K_W | Decoder: iteration count |
| dec_eligible_i | input | 1 | Decoder: word may appear inside a body |
| instr_o | output | WORD_W | Instruction to the decoder |
| instr_valid_o | output | 1 | instr_o is to be executed |
| from_cache_o | output | 1 | instr_o comes from loop storage |
| fast_o | output | 1 | Cached word runs one cycle faster than from memory |
| fetch_hold_o | output | 1 | Program counter must not advance |
| loop_done_o | output | 1 | One-cycle end-of-loop pulse |
| invalid_o | output | 1 | One-cycle invalid-construct pulse |

## Verification
Pass-through words, cached words, the hit flag and the speed flag are combinational from the current state, so each of them is due in the same cycle as its stimulus. The done and invalid pulses and the start of fetch hold are registered, so they are due exactly one clock after the word that causes them. The second setup cycle of a replay follows one clock after the first. The bench drives every input at the falling edge and samples two nanoseconds later, before the next rising edge. Each check therefore reads the cycle that the count of registers predicts, and a pulse that lands one cycle early or late fails.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PREP = 2'd2,
    ST_PLAY = 2'd3
  } zol_state_e;

  localparam int CLS_W = 5;
  localparam logic [CLS_W-1:0] CLS_QUICK_A = 5'h19;
  localparam logic [CLS_W-1:0] CLS_QUICK_B = 5'h1B;
  localparam logic [CLS_W-1:0] CLS_QUICK_C = 5'h1F;

  // classes that shed one cycle when issued from the loop store
  function automatic logic is_quick(input logic [CLS_W-1:0] cls);
    return (cls == CLS_QUICK_A) || (cls == CLS_QUICK_B) || (cls == CLS_QUICK_C);
  endfunction
endpackage

// File: rtl/zol_body_ram.sv
module zol_body_ram #(
  parameter int WORD_W = 16,
  parameter int AW     = 4,
  parameter int DEPTH  = 15
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (int'(waddr_i) < DEPTH)) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = (int'(raddr_i) < DEPTH) ? mem_q[raddr_i] : '0;
endmodule

// File: rtl/zol_seq.sv
module zol_seq
  import zol_pkg::*;
#(
  parameter int NI_W      = 4,
  parameter int K_W       = 7,
  parameter int K_MIN     = 2,
  parameter int PREP_CYC  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_valid_i,
  input  logic            dec_is_loop_i,
  input  logic [NI_W-1:0] dec_ni_i,
  input  logic [K_W-1:0]  dec_k_i,
  input  logic            dec_eligible_i,
  output logic            we_o,
  output logic [NI_W-1:0] waddr_o,
  output logic [NI_W-1:0] raddr_o,
  output logic            play_o,
  output logic            prep_o,
  output logic            done_o,
  output logic            bad_o
);
  localparam int PC_W = $clog2(PREP_CYC + 1);

  zol_state_e      state_q;
  logic [NI_W-1:0] len_q, wptr_q, rptr_q;
  logic [K_W-1:0]  iters_q;
  logic [PC_W-1:0] prep_q;
  logic            valid_q, done_q, bad_q;
  logic            k_ok, start;

  assign k_ok  = dec_k_i >= K_W'(K_MIN);
  assign start = fetch_valid_i && dec_is_loop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      iters_q <= '0;
      prep_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (!k_ok) begin
              bad_q <= 1'b1;
            end else if (dec_ni_i != '0) begin
              state_q <= ST_FILL;
              len_q   <= dec_ni_i;
              wptr_q  <= '0;
              iters_q <= dec_k_i - K_W'(1);
              valid_q <= 1'b0;
            end else if (valid_q) begin
              state_q <= ST_PREP;
              iters_q <= dec_k_i;
              rptr_q  <= '0;
              prep_q  <= '0;
            end else begin
              bad_q <= 1'b1;
            end
          end
        end
        ST_FILL: begin
          if (fetch_valid_i) begin
            if (!dec_eligible_i) begin
              state_q <= ST_IDLE;
              valid_q <= 1'b0;
              bad_q   <= 1'b1;
            end else if (wptr_q == len_q - NI_W'(1)) begin
              state_q <= ST_PLAY;
              rptr_q  <= '0;
              valid_q <= 1'b1;
            end else begin
              wptr_q <= wptr_q + NI_W'(1);
            end
          end
        end
        ST_PREP: begin
          if (prep_q == PC_W'(PREP_CYC - 1)) state_q <= ST_PLAY;
          else prep_q <= prep_q + PC_W'(1);
        end
        ST_PLAY: begin
          if (rptr_q == len_q - NI_W'(1)) begin
            rptr_q <= '0;
            if (iters_q == K_W'(1)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              iters_q <= iters_q - K_W'(1);
            end
          end else begin
            rptr_q <= rptr_q + NI_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign we_o    = (state_q == ST_FILL) && fetch_valid_i && dec_eligible_i;
  assign waddr_o = wptr_q;
  assign raddr_o = rptr_q;
  assign play_o  = state_q == ST_PLAY;
  assign prep_o  = state_q == ST_PREP;
  assign done_o  = done_q;
  assign bad_o   = bad_q;
endmodule

// File: rtl/zol_cache.sv
module zol_cache
  import zol_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NI_W   = 4,
  parameter int K_W    = 7,
  parameter int K_MIN  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] fetch_word_i,
  input  logic              fetch_valid_i,
  input  logic              dec_is_loop_i,
  input  logic [NI_W-1:0]   dec_ni_i,
  input  logic [K_W-1:0]    dec_k_i,
  input  logic              dec_eligible_i,
  output logic [WORD_W-1:0] instr_o,
  output logic              instr_valid_o,
  output logic              from_cache_o,
  output logic              fast_o,
  output logic              fetch_hold_o,
  output logic              loop_done_o,
  output logic              invalid_o
);
  localparam int DEPTH    = (1 << NI_W) - 1;
  localparam int PREP_CYC = 2;

  logic              we, play, prep;
  logic [NI_W-1:0]   waddr, raddr;
  logic [WORD_W-1:0] rdata;

  zol_seq #(
    .NI_W(NI_W), .K_W(K_W), .K_MIN(K_MIN), .PREP_CYC(PREP_CYC)
  ) seq_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fetch_valid_i  (fetch_valid_i),
    .dec_is_loop_i  (dec_is_loop_i),
    .dec_ni_i       (dec_ni_i),
    .dec_k_i        (dec_k_i),
    .dec_eligible_i (dec_eligible_i),
    .we_o           (we),
    .waddr_o        (waddr),
    .raddr_o        (raddr),
    .play_o         (play),
    .prep_o         (prep),
    .done_o         (loop_done_o),
    .bad_o          (invalid_o)
  );

  zol_body_ram #(.WORD_W(WORD_W), .AW(NI_W), .DEPTH(DEPTH)) ram_i (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (fetch_word_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign fetch_hold_o  = play || prep;
  assign from_cache_o  = play;
  assign instr_o       = play ? rdata : fetch_word_i;
  assign instr_valid_o = play || (!prep && fetch_valid_i);
  assign fast_o        = play && is_quick(rdata[WORD_W-1 -: CLS_W]);
endmodule

// File: rtl/zol_cache_chk.sv
module zol_cache_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] fetch_word_i,
  input logic [WORD_W-1:0] instr_o,
  input logic              instr_valid_o,
  input logic              from_cache_o,
  input logic              fast_o,
  input logic              fetch_hold_o,
  input logic              loop_done_o,
  input logic              invalid_o
);
  assert_pass_through_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_hold_o |-> (instr_o == fetch_word_i && !from_cache_o));

  assert_release_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fetch_hold_o) |-> loop_done_o);

  assert_bad_no_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !fetch_hold_o);

  assert_fast_cached_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_o |-> from_cache_o);

  assert_prep_two_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fetch_hold_o) && !from_cache_o) |=> (fetch_hold_o && !from_cache_o));

  assert_prep_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_hold_o && !from_cache_o) |-> !instr_valid_o);

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_done_o |=> !loop_done_o);

  assert_done_after_play_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_done_o |-> $past(from_cache_o));
endmodule

bind zol_cache zol_cache_chk #(.WORD_W(WORD_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_word_i  (fetch_word_i),
  .instr_o       (instr_o),
  .instr_valid_o (instr_valid_o),
  .from_cache_o  (from_cache_o),
  .fast_o        (fast_o),
  .fetch_hold_o  (fetch_hold_o),
  .loop_done_o   (loop_done_o),
  .invalid_o     (invalid_o)
);

// File: tb/zol_cache_tb_top.sv
module zol_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] fw = '0;
  logic        fv = 1'b0, lp = 1'b0, el = 1'b0;
  logic [3:0]  ni = '0;
  logic [6:0]  kk = '0;
  logic [15:0] instr;
  logic        ivalid, hit, fast, hold, done, bad;
  int          total = 0, nbad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  zol_cache dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_word_i(fw), .fetch_valid_i(fv),
    .dec_is_loop_i(lp), .dec_ni_i(ni), .dec_k_i(kk), .dec_eligible_i(el),
    .instr_o(instr), .instr_valid_o(ivalid), .from_cache_o(hit), .fast_o(fast),
    .fetch_hold_o(hold), .loop_done_o(done), .invalid_o(bad)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [15:0] w, input logic v, input logic l,
                     input logic [3:0] n, input logic [6:0] k, input logic e);
    @(negedge clk);
    fw = w; fv = v; lp = l; ni = n; kk = k; el = e;
    #2;
  endtask

  task automatic idle();
    cyc(16'h0000, 1'b0, 1'b0, 4'd0, 7'd0, 1'b1);
  endtask

  function automatic logic quick(input logic [15:0] w);
    return (w[15:11] == 5'h19) || (w[15:11] == 5'h1B) || (w[15:11] == 5'h1F);
  endfunction

  // capture n words then expect passes from the store, then done
  task automatic run_do(input string req, input logic [15:0] body [15], input int n, input int k);
    cyc(16'h7000, 1'b1, 1'b1, 4'(n), 7'(k), 1'b0);
    check({req, " start no hold"}, 32'(hold), 0);
    for (int i = 0; i < n; i++) begin
      cyc(body[i], 1'b1, 1'b0, 4'd0, 7'd0, 1'b1);
      check({req, " fill pass"}, 32'(instr), 32'(body[i]));
      check({req, " fill not cached R6"}, 32'({hit, fast}), 0);
    end
    for (int p = 0; p < k - 1; p++) begin
      for (int i = 0; i < n; i++) begin
        cyc(16'hFFFF, 1'b1, 1'b1, 4'd0, 7'd2, 1'b0); // R11 junk inputs
        check({req, " replay word R11"}, 32'(instr), 32'(body[i]));
        check({req, " replay flags"}, 32'({ivalid, hit, hold}), 32'h7);
        check({req, " fast R6"}, 32'(fast), 32'(quick(body[i])));
      end
    end
    cyc(16'h0ABC, 1'b1, 1'b0, 4'd0, 7'd0, 1'b1);
    check("R9 done pulse", 32'(done), 1);
    check("R9 resume pass", 32'({hold, instr}), 32'h0ABC);
    idle();
    check("R9 done one cycle", 32'(done), 0);
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset outputs", 32'({hold, hit, fast, done, bad}), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_pass();
    cyc(16'h1234, 1'b1, 1'b0, 4'd0, 7'd0, 1'b1);
    check("R2 word", 32'(instr), 32'h1234);
    check("R2 valid/hit", 32'({ivalid, hit}), 32'h2);
    cyc(16'h5678, 1'b0, 1'b0, 4'd0, 7'd0, 1'b1);
    check("R2 invalid slot", 32'(ivalid), 0);
  endtask

  task automatic t_redo_nocache();
    cyc(16'h7000, 1'b1, 1'b1, 4'd0, 7'd3, 1'b1);
    idle();
    check("R8 invalid", 32'(bad), 1);
    check("R8 no hold", 32'(hold), 0);
    check("R1 no valid body", 32'(hit), 0);
  endtask

  task automatic t_do_basic();
    logic [15:0] b [15];
    foreach (b[i]) b[i] = 16'hB001 + 16'(i);
    run_do("R3", b, 3, 3);
  endtask

  task automatic t_bad_k();
    cyc(16'h7000, 1'b1, 1'b1, 4'd3, 7'd1, 1'b1);
    idle();
    check("R4 K=1 invalid", 32'(bad), 1);
    check("R4 K=1 no hold", 32'(hold), 0);
    idle();
    check("R4 pulse width", 32'({bad, hold}), 0);
    cyc(16'h7000, 1'b1, 1'b1, 4'd2, 7'd0, 1'b1);
    idle();
    check("R4 K=0 invalid", 32'({bad, hold}), 32'h2);
  endtask

  task automatic t_fast();
    logic [15:0] b [15];
    foreach (b[i]) b[i] = 16'h0;
    b[0] = 16'hC811; b[1] = 16'hB022; b[2] = 16'hD833; b[3] = 16'hF844;
    run_do("R6", b, 4, 2);
  endtask

  task automatic t_redo();
    logic [15:0] b [4] = '{16'hC811, 16'hB022, 16'hD833, 16'hF844};
    cyc(16'h7100, 1'b1, 1'b1, 4'd0, 7'd2, 1'b1);
    check("R7 redo passes", 32'(hold), 0);
    for (int s = 0; s < 2; s++) begin
      idle();
      check("R7 setup hold", 32'({hold, ivalid, hit}), 32'h4);
    end
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 4; i++) begin
        cyc(16'hEEEE, 1'b1, 1'b0, 4'd0, 7'd0, 1'b1);
        check("R7 replay word", 32'(instr), 32'(b[i]));
        check("R7 replay hit", 32'(hit), 1);
      end
    idle();
    check("R9 redo done", 32'({done, hold}), 32'h2);
  endtask

  task automatic t_inelig();
    cyc(16'h7000, 1'b1, 1'b1, 4'd4, 7'd2, 1'b1);
    cyc(16'h1111, 1'b1, 1'b0, 4'd0, 7'd0, 1'b1);
    cyc(16'h0222, 1'b1, 1'b0, 4'd0, 7'd0, 1'b0);
    idle();
    check("R5 invalid", 32'(bad), 1);
    check("R5 abandoned", 32'(hold), 0);
    cyc(16'h7000, 1'b1, 1'b1, 4'd0, 7'd3, 1'b1);
    idle();
    check("R5 body cleared", 32'({bad, hold}), 32'h2);
  endtask

  task automatic t_gap();
    cyc(16'h7000, 1'b1, 1'b1, 4'd2, 7'd2, 1'b1);
    cyc(16'h3AAA, 1'b1, 1'b0, 4'd0, 7'd0, 1'b1);
    cyc(16'h3999, 1'b0, 1'b0, 4'd0, 7'd0, 1'b1);
    check("R10 gap no hold", 32'(hold), 0);
    cyc(16'h3BBB, 1'b1, 1'b0, 4'd0, 7'd0, 1'b1);
    cyc(16'h0, 1'b0, 1'b0, 4'd0, 7'd0, 1'b1);
    check("R10 first", 32'(instr), 32'h3AAA);
    cyc(16'h0, 1'b0, 1'b0, 4'd0, 7'd0, 1'b1);
    check("R10 second", 32'(instr), 32'h3BBB);
    idle();
    check("R10 done", 32'(done), 1);
  endtask

  task automatic t_full();
    logic [15:0] b [15];
    foreach (b[i]) b[i] = 16'h2000 + 16'(i * 3);
    run_do("R3 full depth", b, 15, 2);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_redo_nocache();
    t_do_basic();
    t_bad_k();
    t_fast();
    t_redo();
    t_inelig();
    t_gap();
    t_full();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, nbad);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      total++; nbad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, nbad);
      $finish;
    end
  end
endmodule